// File: doc/BRIEF.md
# Infrared Core Clock Source and Wake Control

This block holds one 8-bit control and status register that decides which clock reaches an infrared communication core and whether that clock is let through at all. Software picks either the internal PLL or an external clock input, states whether the external clock runs at 40 MHz or 48 MHz, powers the PLL, and can stop the clock to the core. The PLL lock indication can be read back through the same register.

A wake feature lets the core come back without software. While wake is armed, line activity seen on the infrared receiver turns the PLL power on and releases the clock stop. The activity input comes from the line side and is brought into the register clock domain before it is used. The glitch-free clock multiplexer and the analog PLL sit outside the block. They are driven by the select, power and gate-enable outputs, and the PLL reports back on a lock input.

Top module: `irclk_ctl`

## Requirements
- R1: After reset the register reads 0x80. clk_en_o, pll_pwr_o, src_ext_o and ext_40m_o are all 0.
- R2: A write stores bit 7 (clock stop), bit 5 (external source select), bit 4 (external is 40 MHz) and bit 3 (wake armed) and bit 2 (PLL power enable) on the next clock edge. Bits 1:0 always read 0, and writes to them have no effect.
- R3: Bit 6 reads the PLL lock input after two synchronising flops. Writes to bit 6 have no effect.
- R4: pll_pwr_o follows bit 2 and src_ext_o follows bit 5, where 1 selects external and 0 selects the PLL. ext_40m_o follows bit 4.
- R5: clk_en_o is the inverse of bit 7. It is registered, so it changes one clock edge after bit 7 changes.
- R6: With bit 3 set, synchronised activity high on an edge sets bit 2 and clears bit 7 on that edge. The other bits are left unchanged.
- R7: With bit 3 clear, the activity input has no effect on the register.
- R8: The activity input passes through two flops. A level presented before edge 1 first affects the register on edge 3, and a pulse lasting one cycle is enough.
- R9: When a wake and a write fall on the same edge, the wake decides bits 2 and 7 (PLL powered, clock running). The write still decides bits 3, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Register clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe for the register |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Register read value |
| pll_lock_i | input | 1 | PLL lock indication, asynchronous |
| ir_act_i | input | 1 | Infrared line activity, asynchronous |
| pll_pwr_o | output | 1 | PLL power enable |
| src_ext_o | output | 1 | Clock mux select, 1 selects the external input |
| ext_40m_o | output | 1 | External clock is 40 MHz |
| clk_en_o | output | 1 | Clock gate enable towards the infrared core |

## Verification
The bench builds the block with its default two synchroniser stages and an 8-bit register. With these values the wake path takes exactly three edges from activity to register and one more edge to the gate enable, so each check samples an exact cycle. This setup also allows a single-cycle activity pulse to be tested, along with a wake that lands on the same edge as a conflicting write. The lock read-back is tested the same way, with its own two-edge delay.

// File: rtl/irclk_pkg.sv
package irclk_pkg;
  localparam int unsigned REG_W    = 8;
  localparam int unsigned HALT_BIT = 7;
  localparam int unsigned LOCK_BIT = 6;
  localparam int unsigned EXT_BIT  = 5;
  localparam int unsigned F40_BIT  = 4;
  localparam int unsigned WAKE_BIT = 3;
  localparam int unsigned PWR_BIT  = 2;
  localparam logic [REG_W-1:0] RST_VAL = REG_W'(1) << HALT_BIT;

  typedef struct packed {
    logic halt;
    logic ext_sel;
    logic ext_40m;
    logic wake_arm;
    logic pll_on;
  } ctl_t;

  localparam ctl_t CTL_RST = '{halt: 1'b1, ext_sel: 1'b0, ext_40m: 1'b0,
                               wake_arm: 1'b0, pll_on: 1'b0};
endpackage

// File: rtl/irclk_sync.sv
module irclk_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/irclk_reg.sv
module irclk_reg
  import irclk_pkg::*;
#(
  parameter int unsigned W = REG_W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         act_i,
  input  logic         lock_i,
  output ctl_t         ctl_o,
  output logic [W-1:0] rd_data_o
);
  ctl_t ctl_q, ctl_d;
  logic wake_req;

  assign wake_req = ctl_q.wake_arm & act_i;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_en_i) begin
      ctl_d.halt     = wr_data_i[HALT_BIT];
      ctl_d.ext_sel  = wr_data_i[EXT_BIT];
      ctl_d.ext_40m  = wr_data_i[F40_BIT];
      ctl_d.wake_arm = wr_data_i[WAKE_BIT];
      ctl_d.pll_on   = wr_data_i[PWR_BIT];
    end
    // wake overrides software on power and stop
    if (wake_req) begin
      ctl_d.pll_on = 1'b1;
      ctl_d.halt   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctl_q <= CTL_RST;
    else         ctl_q <= ctl_d;
  end

  always_comb begin
    rd_data_o           = '0;
    rd_data_o[HALT_BIT] = ctl_q.halt;
    rd_data_o[LOCK_BIT] = lock_i;
    rd_data_o[EXT_BIT]  = ctl_q.ext_sel;
    rd_data_o[F40_BIT]  = ctl_q.ext_40m;
    rd_data_o[WAKE_BIT] = ctl_q.wake_arm;
    rd_data_o[PWR_BIT]  = ctl_q.pll_on;
  end

  assign ctl_o = ctl_q;

  a_r6_wake_powers_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_q.wake_arm && act_i) |=> (ctl_q.pll_on && !ctl_q.halt));

  a_r7_idle_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i && !(ctl_q.wake_arm && act_i)) |=> $stable(ctl_q));

  a_r9_wake_beats_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && ctl_q.wake_arm && act_i) |=>
      (ctl_q.pll_on && !ctl_q.halt && ctl_q.ext_sel == $past(wr_data_i[EXT_BIT])));
endmodule

// File: rtl/irclk_gate.sv
module irclk_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  output logic clk_en_o
);
  logic en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= ~halt_i;
  end

  assign clk_en_o = en_q;

  a_r5_gate_lags_stop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (clk_en_o != $past(halt_i)));
endmodule

// File: rtl/irclk_ctl.sv
module irclk_ctl
  import irclk_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  output logic [REG_W-1:0] rd_data_o,
  input  logic             pll_lock_i,
  input  logic             ir_act_i,
  output logic             pll_pwr_o,
  output logic             src_ext_o,
  output logic             ext_40m_o,
  output logic             clk_en_o
);
  logic act_s, lock_s;
  ctl_t ctl;

  irclk_sync #(.STAGES(SYNC_STAGES)) u_act_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ir_act_i), .q_o(act_s));

  irclk_sync #(.STAGES(SYNC_STAGES)) u_lock_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pll_lock_i), .q_o(lock_s));

  irclk_reg #(.W(REG_W)) u_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .act_i(act_s), .lock_i(lock_s), .ctl_o(ctl), .rd_data_o(rd_data_o));

  irclk_gate u_gate (
    .clk_i(clk_i), .rst_ni(rst_ni), .halt_i(ctl.halt), .clk_en_o(clk_en_o));

  assign pll_pwr_o = ctl.pll_on;
  assign src_ext_o = ctl.ext_sel;
  assign ext_40m_o = ctl.ext_40m;

  a_r4_outputs_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && !(rd_data_o[WAKE_BIT] && act_s) |=>
      (pll_pwr_o == $past(wr_data_i[PWR_BIT]) && src_ext_o == $past(wr_data_i[EXT_BIT])));
endmodule

// File: tb/tb_irclk_ctl.sv
module tb_irclk_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       lock = 1'b0, act = 1'b0;
  logic       pll_pwr, src_ext, ext_40m, clk_en;
  int         n_chk = 0, n_fail = 0;
  bit         done = 1'b0;

  always #4 clk = ~clk;

  irclk_ctl dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .rd_data_o(rd_data), .pll_lock_i(lock), .ir_act_i(act),
    .pll_pwr_o(pll_pwr), .src_ext_o(src_ext), .ext_40m_o(ext_40m),
    .clk_en_o(clk_en));

  task automatic chk(string req, logic [7:0] act_v, logic [7:0] exp_v);
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act_v, exp_v);
    end
  endtask

  task automatic tick(int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    tick();
    wr_en = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 read", rd_data, 8'h80);
    chk("R1 outs", {4'b0, clk_en, pll_pwr, src_ext, ext_40m}, 8'h00);
  endtask

  task automatic t_write();
    wr(8'hFF);
    chk("R2 R3 stored bits", rd_data, 8'hBC);
    chk("R4 outs", {5'b0, pll_pwr, src_ext, ext_40m}, 8'h07);
    wr(8'h00);
    chk("R2 cleared", rd_data, 8'h00);
    chk("R4 outs low", {5'b0, pll_pwr, src_ext, ext_40m}, 8'h00);
    chk("R5 gate lag", {7'b0, clk_en}, 8'h00);
    tick();
    chk("R5 gate on", {7'b0, clk_en}, 8'h01);
    wr(8'h80);
    chk("R5 gate lag off", {7'b0, clk_en}, 8'h01);
    tick();
    chk("R5 gate off", {7'b0, clk_en}, 8'h00);
  endtask

  task automatic t_lock();
    lock = 1'b1;
    tick();
    chk("R3 lock sync 1", {7'b0, rd_data[6]}, 8'h00);
    tick();
    chk("R3 lock sync 2", {7'b0, rd_data[6]}, 8'h01);
    lock = 1'b0;
    tick(3);
    wr(8'h40);
    chk("R3 lock write ignored", rd_data, 8'h00);
    wr(8'h80);
  endtask

  task automatic t_wake(bit pulse);
    wr(8'h88);
    act = 1'b1;
    if (pulse) begin tick(); act = 1'b0; tick(); end
    else tick(2);
    chk("R8 no effect yet", rd_data, 8'h88);
    tick();
    chk("R6 R8 wake applied", rd_data, 8'h0C);
    chk("R5 gate lag wake", {7'b0, clk_en}, 8'h00);
    act = 1'b0;
    tick();
    chk("R5 gate on wake", {7'b0, clk_en}, 8'h01);
    tick(3);
    wr(8'h80);
  endtask

  task automatic t_no_wake();
    wr(8'h80);
    act = 1'b1;
    tick(6);
    chk("R7 disarmed", rd_data, 8'h80);
    chk("R7 gate stays off", {7'b0, clk_en, pll_pwr}, 8'h00);
    act = 1'b0;
    tick(3);
  endtask

  task automatic t_collide();
    wr(8'h88);
    act = 1'b1;
    tick(2);
    wr(8'hB0);
    chk("R9 wake wins", rd_data, 8'h34);
    act = 1'b0;
    tick(4);
    chk("R9 settled", rd_data, 8'h34);
  endtask

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick();
    t_reset();
    t_write();
    t_lock();
    t_wake(1'b0);
    t_wake(1'b1);
    t_no_wake();
    t_collide();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule